// File: doc/BRIEF.md
# Multithreaded Issue Scheduler with Register Scoreboards

This block sits between instruction decode and operand fetch in a fine-grained multithreaded core. Decoded instructions arrive one per cycle, each tagged with a thread number, and wait in a small queue owned by that thread. Every thread also owns a busy-register bitmap. When an instruction issues, its destination register becomes busy. A waiting instruction that reads or writes a busy register holds back its thread until writeback releases that register.

In each cycle the block works out which threads could issue. A thread can issue when its oldest instruction is free of register hazards and, if it is a floating-point operation, would not finish in the same cycle as a floating-point operation already in flight. One of the ready threads is then granted in rotating order. The granted instruction is presented on a registered output one cycle later.

A branch rollback for a thread empties that thread's queue and replaces its busy bitmap with a snapshot taken from the branch unit. A full queue is reported to fetch as backpressure. All issue pauses while writeback reports that its queues are nearly full.

Top module: `issue_scheduler`

## Requirements
- R1: Instructions of one thread issue in the order they were pushed; each thread queue holds DEPTH entries.
- R2: Issuing an instruction marks its destination register busy in its thread's bitmap. A later instruction of that thread whose src0, src1 or dst names a busy register does not issue. Other threads are not affected.
- R3: A release (rel_valid, rel_tid, rel_map) clears the marked bits of that thread's bitmap from the next cycle onward. If the same register is released and newly set by an issue in one cycle, it stays busy.
- R4: A thread is ready when its queue is non-empty, it has no hazard, it has no floating-point collision and it has no rollback in this cycle. Among ready threads, the grant goes to the first one after the last granted thread, in increasing thread number with wrap-around. After reset, thread 0 has first priority.
- R5: Let push_lat be in 1..FP_LAT_MAX. A floating-point instruction issued in cycle c completes in cycle c+push_lat. A floating-point instruction whose completion cycle equals that of an earlier issued floating-point instruction does not issue.
- R6: A rollback (rb_valid, rb_tid) empties that thread's queue, including a push to that thread in the same cycle. It loads the thread's bitmap with rb_snap, which overrides any release in the same cycle. That thread does not issue in that cycle.
- R7: fifo_full[t] is 1 exactly when thread t's queue holds DEPTH entries. A push to a full queue is dropped.
- R8: While wb_almost_full is 1, nothing issues and no queue or bitmap changes because of issue.
- R9: A grant made in cycle c appears on the iss_* outputs after the clock edge that ends cycle c. iss_valid is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Decoded instruction is offered |
| push_tid | input | TW | Thread of the offered instruction |
| push_src0 | input | RW | First source register |
| push_src1 | input | RW | Second source register |
| push_dst | input | RW | Destination register |
| push_fp | input | 1 | Instruction goes to the floating-point pipe |
| push_lat | input | LW | Floating-point latency in cycles (1..FP_LAT_MAX) |
| push_tag | input | TAGW | Opaque instruction payload returned at issue |
| fifo_full | output | THREADS | Per-thread queue full |
| wb_almost_full | input | 1 | Writeback nearly full: stall all issue |
| rel_valid | input | 1 | Release bitmap is valid |
| rel_tid | input | TW | Thread whose registers are released |
| rel_map | input | REGS | Registers released by writeback |
| rb_valid | input | 1 | Rollback request |
| rb_tid | input | TW | Thread being rolled back |
| rb_snap | input | REGS | Bitmap restored on rollback |
| iss_valid | output | 1 | An instruction issued |
| iss_tid | output | TW | Thread of the issued instruction |
| iss_dst | output | RW | Destination register of the issued instruction |
| iss_fp | output | 1 | Issued instruction is floating point |
| iss_lat | output | LW | Latency of the issued instruction |
| iss_tag | output | TAGW | Payload of the issued instruction |

## Verification
Some events can land in the same cycle. An issue can set a destination bit while writeback releases that same register. A rollback can arrive for a thread that is also receiving a push, or that has a ready instruction. Directed sequences create each of these collisions on purpose, and a long random run creates many more by mixing dense pushes over eight registers with random releases and rollbacks. Every issue, tag and full flag is compared against a cycle model in the bench. That model applies set-over-clear, rollback-over-push and rollback-over-release, so a single wrong priority shows up as a wrong tag or an extra or missing issue.

// File: rtl/issue_scheduler.sv
module issue_scheduler #(
  parameter int THREADS    = 4,
  parameter int REGS       = 32,
  parameter int DEPTH      = 4,
  parameter int TAGW       = 8,
  parameter int FP_LAT_MAX = 6,
  localparam int TW = $clog2(THREADS),
  localparam int RW = $clog2(REGS),
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(FP_LAT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [TW-1:0]     push_tid,
  input  logic [RW-1:0]     push_src0,
  input  logic [RW-1:0]     push_src1,
  input  logic [RW-1:0]     push_dst,
  input  logic              push_fp,
  input  logic [LW-1:0]     push_lat,
  input  logic [TAGW-1:0]   push_tag,
  output logic [THREADS-1:0] fifo_full,
  input  logic              wb_almost_full,
  input  logic              rel_valid,
  input  logic [TW-1:0]     rel_tid,
  input  logic [REGS-1:0]   rel_map,
  input  logic              rb_valid,
  input  logic [TW-1:0]     rb_tid,
  input  logic [REGS-1:0]   rb_snap,
  output logic              iss_valid,
  output logic [TW-1:0]     iss_tid,
  output logic [RW-1:0]     iss_dst,
  output logic              iss_fp,
  output logic [LW-1:0]     iss_lat,
  output logic [TAGW-1:0]   iss_tag
);
  localparam int O_S1  = RW;
  localparam int O_D   = 2 * RW;
  localparam int O_F   = 3 * RW;
  localparam int O_L   = 3 * RW + 1;
  localparam int O_G   = 3 * RW + 1 + LW;
  localparam int IW    = O_G + TAGW;

  logic [IW-1:0]      mem   [THREADS][DEPTH];
  logic [PW-1:0]      rd_p  [THREADS];
  logic [PW-1:0]      wr_p  [THREADS];
  logic [CW-1:0]      cnt   [THREADS];
  logic [REGS-1:0]    sb    [THREADS];
  logic [IW-1:0]      head  [THREADS];
  logic [THREADS-1:0] ready;
  logic [FP_LAT_MAX-1:0] occ;
  logic [TW-1:0]      last, gnt;
  logic               go;

  logic [IW-1:0] push_word;
  assign push_word = {push_tag, push_lat, push_fp, push_dst, push_src1, push_src0};

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [RW-1:0] s0, s1, d;
    logic          fp, hz, fpb, rb_hit, push_ok, pop;
    logic [LW-1:0] lat;

    assign head[t] = mem[t][rd_p[t]];
    assign s0  = head[t][RW-1:0];
    assign s1  = head[t][O_S1 +: RW];
    assign d   = head[t][O_D +: RW];
    assign fp  = head[t][O_F];
    assign lat = head[t][O_L +: LW];

    assign hz  = sb[t][s0] | sb[t][s1] | sb[t][d];
    assign fpb = fp & (lat != '0) & occ[lat - LW'(1)];
    assign rb_hit  = rb_valid && (rb_tid == TW'(t));
    assign push_ok = push_valid && (push_tid == TW'(t)) && (cnt[t] != CW'(DEPTH));
    assign pop     = go && (gnt == TW'(t));

    assign ready[t]     = (cnt[t] != '0) && !rb_hit && !hz && !fpb && !wb_almost_full;
    assign fifo_full[t] = (cnt[t] == CW'(DEPTH));

    always_ff @(posedge clk) begin
      if (push_ok && !rb_hit) mem[t][wr_p[t]] <= push_word;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_p[t] <= '0;
        wr_p[t] <= '0;
        cnt[t]  <= '0;
      end else if (rb_hit) begin
        rd_p[t] <= '0;
        wr_p[t] <= '0;
        cnt[t]  <= '0;
      end else begin
        if (push_ok) wr_p[t] <= (wr_p[t] == PW'(DEPTH - 1)) ? '0 : wr_p[t] + PW'(1);
        if (pop)     rd_p[t] <= (rd_p[t] == PW'(DEPTH - 1)) ? '0 : rd_p[t] + PW'(1);
        cnt[t] <= cnt[t] + CW'(push_ok) - CW'(pop);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        sb[t] <= '0;
      else if (rb_hit)
        sb[t] <= rb_snap;
      else
        sb[t] <= (sb[t] & ~((rel_valid && rel_tid == TW'(t)) ? rel_map : '0))
               | (pop ? (REGS'(1) << d) : '0);
    end
  end

  always_comb begin
    go  = 1'b0;
    gnt = '0;
    for (int k = 1; k <= THREADS; k++) begin
      int j;
      j = (int'(last) + k) % THREADS;
      if (!go && ready[j]) begin
        go  = 1'b1;
        gnt = TW'(j);
      end
    end
  end

  logic [IW-1:0] sel;
  logic [LW-1:0] sel_lat;
  logic          sel_fp;
  assign sel     = head[gnt];
  assign sel_lat = sel[O_L +: LW];
  assign sel_fp  = sel[O_F];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < FP_LAT_MAX; i++)
        occ[i] <= ((i < FP_LAT_MAX - 1) ? occ[(i + 1) % FP_LAT_MAX] : 1'b0)
                | (go && sel_fp && (int'(sel_lat) == i + 2));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last      <= TW'(THREADS - 1);
      iss_valid <= 1'b0;
      iss_tid   <= '0;
      iss_dst   <= '0;
      iss_fp    <= 1'b0;
      iss_lat   <= '0;
      iss_tag   <= '0;
    end else begin
      iss_valid <= go;
      if (go) begin
        last    <= gnt;
        iss_tid <= gnt;
        iss_dst <= sel[O_D +: RW];
        iss_fp  <= sel_fp;
        iss_lat <= sel_lat;
        iss_tag <= sel[O_G +: TAGW];
      end
    end
  end
endmodule

// File: rtl/issue_scheduler_chk.sv
module issue_scheduler_chk #(
  parameter int THREADS    = 4,
  parameter int REGS       = 32,
  parameter int DEPTH      = 4,
  parameter int TAGW       = 8,
  parameter int FP_LAT_MAX = 6,
  localparam int TW = $clog2(THREADS),
  localparam int LW = $clog2(FP_LAT_MAX + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wb_almost_full,
  input logic               rb_valid,
  input logic [TW-1:0]      rb_tid,
  input logic [THREADS-1:0] fifo_full,
  input logic               iss_valid,
  input logic [TW-1:0]      iss_tid,
  input logic               iss_fp,
  input logic [LW-1:0]      iss_lat
);
  logic [FP_LAT_MAX-1:0] busy_at;

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_at <= '0;
    else
      busy_at <= (busy_at >> 1)
               | ((iss_valid && iss_fp && iss_lat >= LW'(2)) ?
                  (FP_LAT_MAX'(1) << (iss_lat - LW'(2))) : '0);
  end

  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_almost_full |=> !iss_valid); // R8

  AST_RB_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |=> !(iss_valid && iss_tid == $past(rb_tid))); // R6

  AST_RB_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |=> !fifo_full[$past(rb_tid)]); // R6

  AST_FP_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_fp && iss_lat != '0) |-> !busy_at[iss_lat - LW'(1)]); // R5
endmodule

bind issue_scheduler issue_scheduler_chk #(
  .THREADS(THREADS), .REGS(REGS), .DEPTH(DEPTH), .TAGW(TAGW), .FP_LAT_MAX(FP_LAT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_almost_full(wb_almost_full),
  .rb_valid(rb_valid), .rb_tid(rb_tid), .fifo_full(fifo_full),
  .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_fp(iss_fp), .iss_lat(iss_lat)
);

// File: tb/sim_issue_scheduler.sv
`timescale 1ns/1ps
module sim_issue_scheduler;
  localparam int T = 4, R = 32, D = 4, G = 8, FM = 6;
  localparam int TW = 2, RW = 5, LW = 3;

  logic clk = 0, rst_n = 0;
  logic push_valid, push_fp, wb_almost_full, rel_valid, rb_valid;
  logic [TW-1:0] push_tid, rel_tid, rb_tid;
  logic [RW-1:0] push_src0, push_src1, push_dst;
  logic [LW-1:0] push_lat;
  logic [G-1:0]  push_tag;
  logic [R-1:0]  rel_map, rb_snap;
  logic [T-1:0]  fifo_full;
  logic iss_valid, iss_fp;
  logic [TW-1:0] iss_tid;
  logic [RW-1:0] iss_dst;
  logic [LW-1:0] iss_lat;
  logic [G-1:0]  iss_tag;

  always #5 clk = ~clk;

  issue_scheduler u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  string lbl = "R9";

  int q_s0[T][D], q_s1[T][D], q_d[T][D], q_fp[T][D], q_lat[T][D], q_tag[T][D];
  int m_rd[T], m_wr[T], m_cnt[T], m_last;
  logic [R-1:0] m_sb[T];
  logic [FM-1:0] m_occ;
  int e_v, e_tid, e_dst, e_fp, e_lat, e_tag;
  int tagc = 0;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", lbl, what, act, exp);
    end
  endtask

  task automatic idle();
    push_valid = 0; push_tid = 0; push_src0 = 0; push_src1 = 0; push_dst = 0;
    push_fp = 0; push_lat = 1; push_tag = 0; wb_almost_full = 0;
    rel_valid = 0; rel_tid = 0; rel_map = 0; rb_valid = 0; rb_tid = 0; rb_snap = 0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < T; t++) begin m_rd[t] = 0; m_wr[t] = 0; m_cnt[t] = 0; m_sb[t] = 0; end
    m_occ = 0; m_last = T - 1; e_v = 0;
  endtask

  function automatic bit rdy(int t);
    int h;
    bit hz, fb;
    if (m_cnt[t] == 0 || wb_almost_full || (rb_valid && rb_tid == t)) return 0;
    h  = m_rd[t];
    hz = m_sb[t][q_s0[t][h]] | m_sb[t][q_s1[t][h]] | m_sb[t][q_d[t][h]];
    fb = q_fp[t][h] != 0 && m_occ[q_lat[t][h] - 1];
    return !hz && !fb;
  endfunction

  task automatic model_step();
    int g, h;
    logic [FM-1:0] no;
    g = -1;
    for (int k = 1; k <= T; k++) if (g < 0 && rdy((m_last + k) % T)) g = (m_last + k) % T;
    e_v = (g >= 0);
    no = m_occ >> 1;
    if (g >= 0) begin
      h = m_rd[g];
      e_tid = g; e_dst = q_d[g][h]; e_fp = q_fp[g][h]; e_lat = q_lat[g][h]; e_tag = q_tag[g][h];
      if (e_fp != 0 && e_lat >= 2) no[e_lat - 2] = 1'b1;
      m_last = g;
    end
    m_occ = no;
    for (int t = 0; t < T; t++) begin
      if (rb_valid && rb_tid == t) begin
        m_sb[t] = rb_snap; m_cnt[t] = 0; m_rd[t] = 0; m_wr[t] = 0;
      end else begin
        bit pu;
        if (rel_valid && rel_tid == t) m_sb[t] &= ~rel_map;
        pu = push_valid && push_tid == t && m_cnt[t] < D;
        if (pu) begin
          q_s0[t][m_wr[t]] = push_src0; q_s1[t][m_wr[t]] = push_src1; q_d[t][m_wr[t]] = push_dst;
          q_fp[t][m_wr[t]] = push_fp; q_lat[t][m_wr[t]] = push_lat; q_tag[t][m_wr[t]] = push_tag;
          m_wr[t] = (m_wr[t] + 1) % D; m_cnt[t]++;
        end
        if (g == t) begin
          m_sb[t][e_dst] = 1'b1;
          m_rd[t] = (m_rd[t] + 1) % D; m_cnt[t]--;
        end
      end
    end
  endtask

  task automatic compare();
    chk(iss_valid == e_v, "iss_valid", iss_valid, e_v);
    if (e_v != 0 && iss_valid) begin
      chk(iss_tid == e_tid && iss_tag == e_tag && iss_dst == e_dst &&
          iss_fp == e_fp && iss_lat == e_lat, "iss_tid/tag", {iss_tid, iss_tag}, {e_tid[TW-1:0], e_tag[G-1:0]});
    end
    for (int t = 0; t < T; t++)
      chk(fifo_full[t] == (m_cnt[t] == D), "fifo_full", fifo_full[t], m_cnt[t] == D);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic push(int t, int s0, int s1, int d, int fp, int lat);
    push_valid = 1; push_tid = TW'(t); push_src0 = RW'(s0); push_src1 = RW'(s1);
    push_dst = RW'(d); push_fp = fp[0]; push_lat = LW'(lat); push_tag = G'(tagc);
    tagc++;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wipe();
    for (int t = 0; t < T; t++) begin
      rb_valid = 1; rb_tid = TW'(t); rb_snap = '0; tick();
    end
    drain(FM + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    lbl = "R9"; compare();

    lbl = "R4";
    for (int t = 0; t < T; t++) begin push(t, 10 + t, 10 + t, 20 + t, 0, 1); tick(); end
    drain(6);

    lbl = "R1";
    for (int i = 0; i < 4; i++) begin push(2, 1, 1, 3 + i, 0, 1); tick(); end
    drain(6); wipe();

    lbl = "R2";
    push(0, 1, 2, 5, 0, 1); tick();
    push(0, 5, 3, 6, 0, 1); tick();
    push(1, 5, 5, 5, 0, 1); tick();
    drain(4);
    lbl = "R3";
    rel_valid = 1; rel_tid = 0; rel_map = 32'h20; tick();
    drain(3); wipe();
    push(1, 0, 0, 9, 0, 1); tick();
    rel_valid = 1; rel_tid = 1; rel_map = 32'h200; tick();
    push(1, 9, 0, 4, 0, 1); tick();
    drain(4); wipe();

    lbl = "R5";
    push(2, 0, 0, 1, 1, 3); tick();
    push(3, 0, 0, 2, 1, 2); tick();
    push(0, 0, 0, 3, 1, 4); tick();
    drain(8); wipe();

    lbl = "R6";
    rel_valid = 1; rel_tid = 0; rel_map = '1; tick();
    push(0, 1, 1, 7, 0, 1); rb_valid = 1; rb_tid = 0; rb_snap = 32'h2; tick();
    push(0, 1, 1, 8, 0, 1); tick();
    push(0, 4, 4, 8, 0, 1); rb_valid = 1; rb_tid = 0; rb_snap = 0;
    rel_valid = 1; rel_tid = 0; rel_map = '1; tick();
    drain(4); wipe();

    lbl = "R7";
    rb_valid = 1; rb_tid = 1; rb_snap = 32'h1; tick();
    for (int i = 0; i < D + 2; i++) begin push(1, 0, 0, 2, 0, 1); tick(); end
    rel_valid = 1; rel_tid = 1; rel_map = '1; tick();
    drain(8); wipe();

    lbl = "R8";
    for (int t = 0; t < T; t++) begin push(t, 1, 1, 2 + t, 0, 1); wb_almost_full = 1; tick(); end
    wb_almost_full = 1; tick();
    drain(6); wipe();

    lbl = "R4";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 10 < 8) begin
        int fp;
        fp = ($urandom % 10 < 3);
        push($urandom % T, $urandom % 8, $urandom % 8, $urandom % 8, fp, 1 + $urandom % FM);
      end
      if ($urandom % 10 < 4) begin
        rel_valid = 1; rel_tid = TW'($urandom % T); rel_map = R'($urandom % 256);
      end
      if ($urandom % 100 < 5) begin
        rb_valid = 1; rb_tid = TW'($urandom % T); rb_snap = R'(($urandom & $urandom) % 256);
      end
      wb_almost_full = ($urandom % 10 == 0);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule